// File: doc/BRIEF.md
# Inter-Processor Mailbox with Ownership Arbitration

This block is a shared register mailbox between host software and an embedded controller. Each side has its own simple register port. The host port is a memory-mapped request/write/address/data port. The controller port has the same parallel form. Both ports see the same five registers, and read data follows the address combinationally. Before a side posts a message word, it claims the mailbox through a three-valued owner register. A control register then routes an interrupt to one of four destinations. Replies (ACK or NAK) are posted without a claim, because the other side still holds the mailbox at that point.

A message word holds a command type in bits 31:24 and a payload in bits 23:0. Some command types need no acknowledgement: set-bandwidth (6), ACK (128) and NAK (129). When one of these is accepted, the receiving side may release the owner register even though it does not hold it. A sticky firmware-hang flag with a write-one-to-clear action, and a hardware reply timer, complete the block. The timer flags a host request whose owner register has not returned to empty within a set window.

Register addresses: 0 owner, 1 control, 2 host-to-controller word, 3 controller-to-host word, 4 status. Unused read bits return 0.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the owner register (address 0, bits 1:0; 0 none, 1 controller, 2 host) reads 0 on both ports. All other registers read 0, dest_irq_o is 0 and reply_timeout_o is 0.
- R2: Writing the side's own code to the owner register claims it, but only when the owner reads 0. The host writes 2 and the controller writes 1. When both sides claim in the same cycle, the host wins.
- R3: An owner write is ignored in each of these cases: it is a claim made while the owner is nonzero, it carries the other side's code, or it carries the value 3.
- R4: A write of 0 to the owner register is honoured from the current owner. From the other side it is ignored unless R6 applies.
- R5: The host writes its message word at address 2 and the controller writes its word at address 3. Each write is accepted only while the writer owns the mailbox. A word whose type (bits 31:24) is 128 or 129 is accepted regardless of ownership.
- R6: After an accepted word of type 6, 128 or 129, the receiving side may write 0 to the owner register while it is not the owner. This permission ends when the owner next returns to 0 or when another word is accepted.
- R7: The control register holds bits 31:27 at address 1, and its other bits read 0. Bit 27 selects the controller, bit 28 PME, bit 29 SMI, bit 30 the host controller, and bit 31 is the interrupt enable. Either side may write it, and the host wins a same-cycle collision. dest_irq_o[i] equals bit 31 AND bit 27+i.
- R8: The status register sits at address 4. Bit 1 is the hang flag: hang_i sets it and a host write of 1 to bit 1 clears it. Setting wins over clearing. Bit 3 is an enable that takes the value of each host write. dest_irq_o[2] is also driven by enable AND hang.
- R9: A host write to the control register that sets bits 31 and 27 starts the reply wait, but only when the current host word's type needs acknowledgement. If the owner has not reached 0 when TIMEOUT_CYCLES clock edges have passed, reply_timeout_o rises. The next such post clears it, and the owner reaching 0 ends the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_req_i | input | 1 | Host access strobe |
| h_we_i | input | 1 | Host write enable |
| h_addr_i | input | 3 | Host register address |
| h_wdata_i | input | 32 | Host write data |
| h_rdata_o | output | 32 | Host read data (combinational) |
| c_req_i | input | 1 | Controller access strobe |
| c_we_i | input | 1 | Controller write enable |
| c_addr_i | input | 3 | Controller register address |
| c_wdata_i | input | 32 | Controller write data |
| c_rdata_o | output | 32 | Controller read data (combinational) |
| hang_i | input | 1 | Firmware hang event |
| dest_irq_o | output | 4 | Interrupts: controller, PME, SMI, host controller |
| reply_timeout_o | output | 1 | Host reply wait expired |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 40. At that value the expiry edge of the reply timer can be checked exactly, one cycle before and on the edge itself. It also checks that a release inside the window stops the wait. All other widths keep their defaults. Ownership races, reply bypass, receiver release and status flag priority are all covered in cycles that the default window would hide behind a 25-million-cycle wait.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;
  localparam int TYPE_LSB = 24;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_FW   = 2'd1,
    OWN_SW   = 2'd2
  } owner_e;

  localparam logic [ADDR_W-1:0] A_OWNER   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd1;
  localparam logic [ADDR_W-1:0] A_TO_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_TO_HOST = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT    = 3'd4;

  localparam logic [7:0] T_SET_BW = 8'd6;
  localparam logic [7:0] T_ACK    = 8'd128;
  localparam logic [7:0] T_NAK    = 8'd129;

  localparam int CTL_LSB  = 27;
  localparam int N_DEST   = 4;
  localparam int ST_HANG  = 1;
  localparam int ST_EN    = 3;

  function automatic logic is_reply(input logic [7:0] t);
    return (t == T_ACK) || (t == T_NAK);
  endfunction

  function automatic logic no_ack(input logic [7:0] t);
    return is_reply(t) || (t == T_SET_BW);
  endfunction
endpackage

// File: rtl/mbox_owner.sv
module mbox_owner
  import mbox_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   h_wr_i,
  input  logic [1:0] h_val_i,
  input  logic   h_rel_ok_i,
  input  logic   c_wr_i,
  input  logic [1:0] c_val_i,
  input  logic   c_rel_ok_i,
  output owner_e owner_o,
  output logic   freed_o
);
  owner_e owner_q, owner_d;
  logic h_claim, h_free, c_claim, c_free;

  always_comb begin
    h_claim = h_wr_i && (h_val_i == OWN_SW) && (owner_q == OWN_NONE);
    h_free  = h_wr_i && (h_val_i == OWN_NONE) && (owner_q != OWN_NONE) &&
              ((owner_q == OWN_SW) || h_rel_ok_i);
    c_claim = c_wr_i && (c_val_i == OWN_FW) && (owner_q == OWN_NONE);
    c_free  = c_wr_i && (c_val_i == OWN_NONE) && (owner_q != OWN_NONE) &&
              ((owner_q == OWN_FW) || c_rel_ok_i);
    owner_d = owner_q;
    if (h_claim)      owner_d = OWN_SW;
    else if (h_free)  owner_d = OWN_NONE;
    else if (c_claim) owner_d = OWN_FW;
    else if (c_free)  owner_d = OWN_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_d;

  assign owner_o = owner_q;
  assign freed_o = (owner_q != OWN_NONE) && (owner_d == OWN_NONE);

  a_r1_owner_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_q != 2'd3);
  a_r3_no_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(owner_q) != OWN_NONE) |-> (owner_q == $past(owner_q) || owner_q == OWN_NONE));
  a_r2_host_claim_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_SW && $past(owner_q) != OWN_SW) |-> $past(h_wr_i && h_val_i == OWN_SW));
endmodule

// File: rtl/mbox_reply_timer.sv
module mbox_reply_timer #(
  parameter int LIMIT = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic owner_zero_i,
  output logic timeout_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic busy_q, to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; busy_q <= 1'b0; to_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0; busy_q <= 1'b1; to_q <= 1'b0;
    end else if (busy_q) begin
      if (owner_zero_i) busy_q <= 1'b0;
      else if (cnt_q == LAST) begin
        busy_q <= 1'b0; to_q <= 1'b1;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = to_q;

  a_r9_timeout_owner_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_q) |-> !$past(owner_zero_i));
  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !to_q);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_req_i,
  input  logic              h_we_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic [WORD_W-1:0] h_wdata_i,
  output logic [WORD_W-1:0] h_rdata_o,
  input  logic              c_req_i,
  input  logic              c_we_i,
  input  logic [ADDR_W-1:0] c_addr_i,
  input  logic [WORD_W-1:0] c_wdata_i,
  output logic [WORD_W-1:0] c_rdata_o,
  input  logic              hang_i,
  output logic [N_DEST-1:0] dest_irq_o,
  output logic              reply_timeout_o
);
  localparam int CTL_W = WORD_W - CTL_LSB;

  owner_e owner;
  logic freed;
  logic [CTL_W-1:0] ctrl_q;
  logic [WORD_W-1:0] to_ctrl_q, to_host_q;
  logic hang_q, en_q, rel_ok_q, rel_host_q;

  logic h_wr, c_wr, h_msg_acc, c_msg_acc, h_stat_wr, h_stat_clr, post_start;
  logic [7:0] h_type, c_type;

  assign h_wr   = h_req_i & h_we_i;
  assign c_wr   = c_req_i & c_we_i;
  assign h_type = h_wdata_i[WORD_W-1:TYPE_LSB];
  assign c_type = c_wdata_i[WORD_W-1:TYPE_LSB];

  assign h_msg_acc  = h_wr && (h_addr_i == A_TO_CTRL) && ((owner == OWN_SW) || is_reply(h_type));
  assign c_msg_acc  = c_wr && (c_addr_i == A_TO_HOST) && ((owner == OWN_FW) || is_reply(c_type));
  assign h_stat_wr  = h_wr && (h_addr_i == A_STAT);
  assign h_stat_clr = h_stat_wr && h_wdata_i[ST_HANG];
  assign post_start = h_wr && (h_addr_i == A_CTRL) && h_wdata_i[WORD_W-1] && h_wdata_i[CTL_LSB] &&
                      !no_ack(to_ctrl_q[WORD_W-1:TYPE_LSB]);

  mbox_owner u_owner (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .h_wr_i     (h_wr && (h_addr_i == A_OWNER)),
    .h_val_i    (h_wdata_i[1:0]),
    .h_rel_ok_i (rel_ok_q && rel_host_q),
    .c_wr_i     (c_wr && (c_addr_i == A_OWNER)),
    .c_val_i    (c_wdata_i[1:0]),
    .c_rel_ok_i (rel_ok_q && !rel_host_q),
    .owner_o    (owner),
    .freed_o    (freed)
  );

  mbox_reply_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (post_start),
    .owner_zero_i (owner == OWN_NONE),
    .timeout_o    (reply_timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; to_ctrl_q <= '0; to_host_q <= '0;
      hang_q <= 1'b0; en_q <= 1'b0; rel_ok_q <= 1'b0; rel_host_q <= 1'b0;
    end else begin
      if (h_msg_acc) to_ctrl_q <= h_wdata_i;
      if (c_msg_acc) to_host_q <= c_wdata_i;
      // receiver of a no-ack word may release
      if (h_msg_acc) begin
        rel_ok_q <= no_ack(h_type); rel_host_q <= 1'b0;
      end else if (c_msg_acc) begin
        rel_ok_q <= no_ack(c_type); rel_host_q <= 1'b1;
      end else if (freed) rel_ok_q <= 1'b0;
      if (h_wr && h_addr_i == A_CTRL)      ctrl_q <= h_wdata_i[WORD_W-1:CTL_LSB];
      else if (c_wr && c_addr_i == A_CTRL) ctrl_q <= c_wdata_i[WORD_W-1:CTL_LSB];
      hang_q <= hang_i | (hang_q & ~h_stat_clr);
      if (h_stat_wr) en_q <= h_wdata_i[ST_EN];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_DEST; gi++) begin : g_dest
      if (gi == 2) begin : g_smi
        assign dest_irq_o[gi] = (ctrl_q[CTL_W-1] & ctrl_q[gi]) | (en_q & hang_q);
      end else begin : g_plain
        assign dest_irq_o[gi] = ctrl_q[CTL_W-1] & ctrl_q[gi];
      end
    end
  endgenerate

  logic [ADDR_W-1:0] p_addr [2];
  logic [WORD_W-1:0] p_rdata [2];
  assign p_addr[0] = h_addr_i;
  assign p_addr[1] = c_addr_i;
  assign h_rdata_o = p_rdata[0];
  assign c_rdata_o = p_rdata[1];

  generate
    for (gi = 0; gi < 2; gi++) begin : g_rd
      always_comb begin
        p_rdata[gi] = '0;
        case (p_addr[gi])
          A_OWNER:   p_rdata[gi][1:0] = owner;
          A_CTRL:    p_rdata[gi][WORD_W-1:CTL_LSB] = ctrl_q;
          A_TO_CTRL: p_rdata[gi] = to_ctrl_q;
          A_TO_HOST: p_rdata[gi] = to_host_q;
          A_STAT: begin
            p_rdata[gi][ST_HANG] = hang_q;
            p_rdata[gi][ST_EN]   = en_q;
          end
          default: p_rdata[gi] = '0;
        endcase
      end
    end
  endgenerate

  a_r5_host_word_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(to_ctrl_q) |-> ($past(owner) == OWN_SW || is_reply(to_ctrl_q[WORD_W-1:TYPE_LSB])));
  a_r5_ctrl_word_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(to_host_q) |-> ($past(owner) == OWN_FW || is_reply(to_host_q[WORD_W-1:TYPE_LSB])));
  a_r8_hang_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hang_q) && !$past(h_stat_clr)) |-> hang_q);
  a_r6_rel_ends_on_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freed && !h_msg_acc && !c_msg_acc) |=> !rel_ok_q);
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;
  localparam int NV = 21;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic h_req = 0, h_we = 0, c_req = 0, c_we = 0, hang = 0;
  logic [2:0] h_addr = 0, c_addr = 0;
  logic [31:0] h_wdata = 0, c_wdata = 0, h_rdata, c_rdata;
  logic [3:0] dest_irq;
  logic tmo;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .h_req_i(h_req), .h_we_i(h_we), .h_addr_i(h_addr), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .c_req_i(c_req), .c_we_i(c_we), .c_addr_i(c_addr), .c_wdata_i(c_wdata), .c_rdata_o(c_rdata),
    .hang_i(hang), .dest_irq_o(dest_irq), .reply_timeout_o(tmo)
  );

  // {req, side(0 host,1 ctrl), addr, wdata, expected readback}
  localparam logic [75:0] VEC [NV] = '{
    {4'd3, 4'd1, 4'd0, 32'h0000_0002, 32'h0000_0000}, // R3 other side's code
    {4'd3, 4'd0, 4'd0, 32'h0000_0003, 32'h0000_0000}, // R3 value 3
    {4'd5, 4'd0, 4'd2, 32'h0512_3456, 32'h0000_0000}, // R5 no owner
    {4'd2, 4'd0, 4'd0, 32'h0000_0002, 32'h0000_0002}, // R2 host claim
    {4'd3, 4'd1, 4'd0, 32'h0000_0001, 32'h0000_0002}, // R3 claim while held
    {4'd4, 4'd1, 4'd0, 32'h0000_0000, 32'h0000_0002}, // R4 non-owner release
    {4'd5, 4'd0, 4'd2, 32'h05AB_CDEF, 32'h05AB_CDEF}, // R5 owner word
    {4'd5, 4'd1, 4'd3, 32'h0100_0001, 32'h0000_0000}, // R5 non-owner word
    {4'd5, 4'd1, 4'd3, 32'h8000_0007, 32'h8000_0007}, // R5 ACK bypass
    {4'd4, 4'd0, 4'd0, 32'h0000_0000, 32'h0000_0000}, // R4 owner release
    {4'd2, 4'd1, 4'd0, 32'h0000_0001, 32'h0000_0001}, // R2 ctrl claim
    {4'd5, 4'd1, 4'd3, 32'h0600_0010, 32'h0600_0010}, // R5 set-bw
    {4'd6, 4'd0, 4'd0, 32'h0000_0000, 32'h0000_0000}, // R6 receiver release
    {4'd2, 4'd1, 4'd0, 32'h0000_0001, 32'h0000_0001}, // R2
    {4'd5, 4'd1, 4'd3, 32'h0200_0000, 32'h0200_0000}, // R5 needs ack
    {4'd5, 4'd0, 4'd2, 32'h8100_0002, 32'h8100_0002}, // R5 NAK bypass
    {4'd6, 4'd0, 4'd0, 32'h0000_0000, 32'h0000_0001}, // R6 sender may not release
    {4'd4, 4'd1, 4'd0, 32'h0000_0000, 32'h0000_0000}, // R4
    {4'd7, 4'd0, 4'd1, 32'hFFFF_FFFF, 32'hF800_0000}, // R7 masked bits
    {4'd7, 4'd1, 4'd1, 32'h0000_0000, 32'h0000_0000}, // R7 ctrl write
    {4'd7, 4'd1, 4'd1, 32'h8800_0000, 32'h8800_0000}  // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit side, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    if (side) begin c_req = 1; c_we = 1; c_addr = a; c_wdata = d; end
    else      begin h_req = 1; h_we = 1; h_addr = a; h_wdata = d; end
    @(negedge clk);
    h_req = 0; h_we = 0; c_req = 0; c_we = 0;
  endtask

  task automatic wr_both(input logic [2:0] a, input logic [31:0] hd, input logic [31:0] cd);
    @(negedge clk);
    h_req = 1; h_we = 1; h_addr = a; h_wdata = hd;
    c_req = 1; c_we = 1; c_addr = a; c_wdata = cd;
    @(negedge clk);
    h_req = 0; h_we = 0; c_req = 0; c_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    h_addr = a; #1; d = h_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 reset reg", d, 32'h0);
    end
    c_addr = 3'd0; #1; chk("R1 ctrl port owner", c_rdata, 32'h0);
    chk("R1 irq", {28'h0, dest_irq}, 32'h0);
    chk("R1 timeout", {31'h0, tmo}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:68] != 0, VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], d);
      checks++;
      if (d !== VEC[i][31:0]) begin
        errors++;
        $display("FAIL R%0d row %0d actual=%h expected=%h", VEC[i][75:72], i, d, VEC[i][31:0]);
      end
    end

    // R7 routing and collision
    chk("R7 dest ctrl", {28'h0, dest_irq}, 32'h1);
    wr_both(3'd1, 32'h9000_0000, 32'hA000_0000);
    rd(3'd1, d); chk("R7 host wins ctrl", d, 32'h9000_0000);
    chk("R7 dest pme", {28'h0, dest_irq}, 32'h2);
    // R2 claim collision
    wr_both(3'd0, 32'h2, 32'h1);
    rd(3'd0, d); chk("R2 host wins claim", d, 32'h2);
    wr(0, 3'd0, 32'h0);
    rd(3'd0, d); chk("R4 release after race", d, 32'h0);

    // R8 status
    @(negedge clk); hang = 1; @(negedge clk); hang = 0;
    rd(3'd4, d); chk("R8 hang set", d, 32'h2);
    chk("R8 smi masked", {31'h0, dest_irq[2]}, 32'h0);
    wr(0, 3'd4, 32'h8);
    rd(3'd4, d); chk("R8 enable", d, 32'hA);
    chk("R8 smi raised", {31'h0, dest_irq[2]}, 32'h1);
    wr(0, 3'd4, 32'hA);
    rd(3'd4, d); chk("R8 w1c", d, 32'h8);
    chk("R8 smi dropped", {31'h0, dest_irq[2]}, 32'h0);
    hang = 1;
    wr(0, 3'd4, 32'h2);
    hang = 0;
    rd(3'd4, d); chk("R8 set wins", d, 32'h2);
    wr(0, 3'd4, 32'h2);
    rd(3'd4, d); chk("R8 cleared", d, 32'h0);

    // R9 reply timer
    wr(0, 3'd0, 32'h2);
    wr(0, 3'd2, 32'h0300_0000);
    wr(0, 3'd1, 32'h8800_0000);
    chk("R9 idle at post", {31'h0, tmo}, 32'h0);
    repeat (TMO - 1) @(negedge clk);
    #1 chk("R9 before expiry", {31'h0, tmo}, 32'h0);
    @(negedge clk);
    #1 chk("R9 at expiry", {31'h0, tmo}, 32'h1);
    wr(0, 3'd1, 32'h8800_0000);
    chk("R9 cleared by post", {31'h0, tmo}, 32'h0);
    repeat (3) @(negedge clk);
    wr(0, 3'd0, 32'h0);
    repeat (TMO + 5) @(negedge clk);
    #1 chk("R9 release stops wait", {31'h0, tmo}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule